// File: doc/BRIEF.md
# Vectored Level Interrupt Controller

This block gathers ninety-six interrupt requests into three 32-bit banks and presents one interrupt line to the processor. Each bank has three registers. A pending register latches requests and is cleared by writing ones. An enable register lets a source reach the processor. A mask register hides a source while still recording it. Software reads a vector register that gives the number of the lowest-numbered source that is live, already multiplied by four. A vector of zero tells the service loop to stop, so source 0 never appears as a vector.

Source 0 is not a normal request line. It records events on a dedicated non-maskable pin. A two-bit sense control chooses whether that pin is seen as a low level, a high level, a falling edge or a rising edge. A one-bit protection register and a read-only view of masked-but-enabled pending sources complete the register set. Access is through a plain 32-bit single-cycle register port: a write strobe, an address and write data, with read data returned combinationally for the presented address. This port has no back-pressure, because every access completes in the cycle it is presented.

Top module: `vic_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and `cpu_irq` is low.
- R2: Source k sits in bank k/32 at bit k mod 32. Byte addresses: vector 0x00, protection 0x08, sense control 0x0C, pending 0x10/0x14/0x18, masked view 0x20/0x24/0x28, enable 0x40/0x44/0x48, mask 0x50/0x54/0x58. Any other address reads zero and ignores writes.
- R3: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R4: Sources are level-sensitive. A pending bit is set on every clock edge where its input is high. On an edge where a clear write hits that bit, the clear wins, and the bit sets again on the following edge if the input is still high.
- R5: The vector register returns the source number in bits [8:2]. All other bits read zero, and writes to it are ignored.
- R6: A source is live when it is pending, enabled and not masked. The vector reports the lowest-numbered live source in 1..95, or 0 when there is none.
- R7: A mask bit of 1 removes its source from the vector and from `cpu_irq`, but the pending bit still latches.
- R8: `cpu_irq` is a register. It is high one cycle after any source from 1 to 95 is live, and it is never raised by source 0.
- R9: Source 0 is set from `nmi_pin` as selected by sense control bits [1:0]: 0 low level, 1 high level, 2 falling edge, 3 rising edge. It never appears in the vector.
- R10: The protection register stores write data bit 0. Its other bits read zero.
- R11: Masked view bank n reads pending AND enable AND mask. Writes to it are ignored.
- R12: The sense control register stores write data bits [1:0]. Its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | 95 | Level request lines for sources 95..1 |
| nmi_pin | input | 1 | Non-maskable event pin feeding source 0 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The clear-by-write path and the level relatch path can hit the same pending bit on the same clock edge. The bench holds a source high and writes a one to its pending bit. It then samples that bank right after the write edge, where it expects zero, and again one edge later, where it expects the bit set again. A reference model runs every cycle and predicts `cpu_irq`. It catches any mismatch caused by ordering the clear against latching a new request, or against changes to enable and mask.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 3;
  localparam int NUM_SRC   = BANK_W * NUM_BANKS;

  localparam logic [7:0] OFS_VEC  = 8'h00;
  localparam logic [7:0] OFS_PROT = 8'h08;
  localparam logic [7:0] OFS_SNS  = 8'h0C;
  localparam logic [7:0] OFS_PEND = 8'h10;
  localparam logic [7:0] OFS_MVW  = 8'h20;
  localparam logic [7:0] OFS_EN   = 8'h40;
  localparam logic [7:0] OFS_MASK = 8'h50;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'd0,
    SNS_HIGH = 2'd1,
    SNS_FALL = 2'd2,
    SNS_RISE = 2'd3
  } sense_mode_e;
endpackage

// File: rtl/vic_nmi_sense.sv
module vic_nmi_sense
  import vic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pin,
  input  sense_mode_e mode,
  output logic        hit
);
  logic pin_d;

  always_ff @(posedge clk) begin
    if (!rst_n) pin_d <= 1'b0;
    else        pin_d <= pin;
  end

  always_comb begin
    unique case (mode)
      SNS_LOW:  hit = !pin;
      SNS_HIGH: hit = pin;
      SNS_FALL: hit = pin_d && !pin;
      SNS_RISE: hit = !pin_d && pin;
      default:  hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/vic_bank.sv
module vic_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         wr_pend,
  input  logic         wr_en,
  input  logic         wr_mask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic [W-1:0] mask
);
  logic [W-1:0] clr;
  assign clr = wr_pend ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
      mask <= '0;
    end else begin
      pend <= (pend | src) & ~clr;
      if (wr_en)   en   <= wdata;
      if (wr_mask) mask <= wdata;
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N     = 96,
  parameter int IDX_W = 7
) (
  input  logic [N-1:1]     live,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 1; i--) begin
      if (live[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NB     = NUM_BANKS,
  parameter int BW     = BANK_W,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NB*BW-1:1]     irq_src,
  input  logic                 nmi_pin,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BW-1:0]        bus_wdata,
  output logic [BW-1:0]        bus_rdata,
  output logic                 cpu_irq
);
  localparam int NS    = NB * BW;
  localparam int IDX_W = $clog2(NS);

  logic [NS-1:0]    pend_all, en_all, mask_all, src_all, live_all;
  logic [NB-1:0]    wr_pend, wr_en, wr_mask;
  logic             nmi_hit, prot_q, irq_q;
  sense_mode_e      sns_q;
  logic [IDX_W-1:0] vec_idx;

  vic_nmi_sense u_sense (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (nmi_pin),
    .mode (sns_q),
    .hit  (nmi_hit)
  );

  assign src_all = {irq_src, nmi_hit};

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign wr_pend[b] = bus_wr && (bus_addr == ADDR_W'(OFS_PEND + 4 * b));
    assign wr_en[b]   = bus_wr && (bus_addr == ADDR_W'(OFS_EN + 4 * b));
    assign wr_mask[b] = bus_wr && (bus_addr == ADDR_W'(OFS_MASK + 4 * b));

    vic_bank #(.W(BW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_all[b*BW +: BW]),
      .wr_pend(wr_pend[b]),
      .wr_en  (wr_en[b]),
      .wr_mask(wr_mask[b]),
      .wdata  (bus_wdata),
      .pend   (pend_all[b*BW +: BW]),
      .en     (en_all[b*BW +: BW]),
      .mask   (mask_all[b*BW +: BW])
    );
  end

  assign live_all = pend_all & en_all & ~mask_all;

  vic_prio #(.N(NS), .IDX_W(IDX_W)) u_prio (
    .live(live_all[NS-1:1]),
    .idx (vec_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_q <= 1'b0;
      sns_q  <= SNS_LOW;
      irq_q  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADDR_W'(OFS_PROT)) prot_q <= bus_wdata[0];
      if (bus_wr && bus_addr == ADDR_W'(OFS_SNS))  sns_q  <= sense_mode_e'(bus_wdata[1:0]);
      irq_q <= |live_all[NS-1:1];
    end
  end

  assign cpu_irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_VEC))  bus_rdata = BW'({vec_idx, 2'b00});
    if (bus_addr == ADDR_W'(OFS_PROT)) bus_rdata = BW'(prot_q);
    if (bus_addr == ADDR_W'(OFS_SNS))  bus_rdata = BW'(sns_q);
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == ADDR_W'(OFS_PEND + 4 * b)) bus_rdata = pend_all[b*BW +: BW];
      if (bus_addr == ADDR_W'(OFS_MVW + 4 * b))
        bus_rdata = pend_all[b*BW +: BW] & en_all[b*BW +: BW] & mask_all[b*BW +: BW];
      if (bus_addr == ADDR_W'(OFS_EN + 4 * b))   bus_rdata = en_all[b*BW +: BW];
      if (bus_addr == ADDR_W'(OFS_MASK + 4 * b)) bus_rdata = mask_all[b*BW +: BW];
    end
  end
endmodule

// File: rtl/vic_irq_checker.sv
module vic_irq_checker
  import vic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_SRC-1:1] irq_src,
  input logic              bus_wr,
  input logic [7:0]        bus_addr,
  input logic [BANK_W-1:0] bus_wdata,
  input logic [BANK_W-1:0] bus_rdata,
  input logic              cpu_irq,
  input logic [NUM_SRC-1:0] pend_all,
  input logic [NUM_SRC-1:0] en_all,
  input logic [NUM_SRC-1:0] mask_all
);
  logic [NUM_SRC-1:0] live;
  logic               pend_wr;
  assign live    = pend_all & en_all & ~mask_all;
  assign pend_wr = bus_wr && (bus_addr == OFS_PEND || bus_addr == OFS_PEND + 8'd4 ||
                              bus_addr == OFS_PEND + 8'd8);

  // R3: a one written to bank 0 pending leaves that bit clear after the edge
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_PEND) |=> ((pend_all[BANK_W-1:0] & $past(bus_wdata)) == '0));

  // R4: with no clear write, every high input is pending after the edge
  a_r4_level_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr |=> ((pend_all[NUM_SRC-1:1] & $past(irq_src)) == $past(irq_src)));

  // R8: no live source 1..95 means the line is low next cycle
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (live[NUM_SRC-1:1] == '0) |=> !cpu_irq);

  // R8: any live source 1..95 raises the line next cycle
  a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (live[NUM_SRC-1:1] != '0) |=> cpu_irq);

  // R5: vector read has only bits [8:2] populated
  a_r5_vec_format: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_VEC) |-> (bus_rdata[1:0] == 2'b00 && bus_rdata[BANK_W-1:9] == '0));

  // R6/R7: a reported vector names a live, unmasked source
  a_r7_vec_is_live: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_VEC && bus_rdata != '0) |-> (((live >> bus_rdata[8:2]) & NUM_SRC'(1)) != '0));
endmodule

bind vic_irq_ctrl vic_irq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_src  (irq_src),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .cpu_irq  (cpu_irq),
  .pend_all (pend_all),
  .en_all   (en_all),
  .mask_all (mask_all)
);

// File: tb/test_vic_irq_ctrl.sv
module test_vic_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:1] irq_src = '0;
  logic        nmi_pin = 1'b1;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  vic_irq_ctrl i_vic_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .nmi_pin(nmi_pin),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  // behavioural reference model, advanced on each edge
  logic [95:0] m_pend, m_en, m_mask;
  logic [1:0]  m_mode;
  logic        m_prev, m_irq;

  always @(posedge clk) begin
    logic [95:0] src, clr, live;
    logic        hit;
    if (!rst_n) begin
      m_pend <= '0; m_en <= '0; m_mask <= '0;
      m_mode <= '0; m_prev <= 1'b0; m_irq <= 1'b0;
    end else begin
      case (m_mode)
        2'd0: hit = !nmi_pin;
        2'd1: hit = nmi_pin;
        2'd2: hit = m_prev && !nmi_pin;
        default: hit = !m_prev && nmi_pin;
      endcase
      src = {irq_src, hit};
      clr = '0;
      if (bus_wr) begin
        for (int b = 0; b < 3; b++) begin
          if (bus_addr == 8'h10 + 8'(4 * b)) clr[b*32 +: 32] = bus_wdata;
          if (bus_addr == 8'h40 + 8'(4 * b)) m_en[b*32 +: 32] <= bus_wdata;
          if (bus_addr == 8'h50 + 8'(4 * b)) m_mask[b*32 +: 32] <= bus_wdata;
        end
        if (bus_addr == 8'h0C) m_mode <= bus_wdata[1:0];
      end
      live = m_pend & m_en & ~m_mask;
      live[0] = 1'b0;
      m_irq  <= |live;
      m_pend <= (m_pend | src) & ~clr;
      m_prev <= nmi_pin;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R8: per-cycle comparison of the interrupt line against the model
  always @(negedge clk) begin
    if (rst_n && !done) chk("R8 cpu_irq vs model", 32'(cpu_irq), 32'(m_irq));
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #2;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    foreach (OFFS[i]) rd(OFFS[i], 32'h0, "R1 reset read");
    chk("R1 cpu_irq after reset", 32'(cpu_irq), 32'h0);

    wr(8'h40, '1); wr(8'h44, '1); wr(8'h48, '1);
    irq_src[40] = 1'b1;
    rd(8'h00, 32'hA0, "R5 vector of source 40");
    rd(8'h14, 32'h100, "R2 source 40 in bank 1 bit 8");
    @(negedge clk);
    chk("R8 line high", 32'(cpu_irq), 32'h1);

    irq_src[7] = 1'b1; irq_src[95] = 1'b1;
    rd(8'h00, 32'h1C, "R6 lowest live wins");
    wr(8'h50, 32'h80);
    rd(8'h00, 32'hA0, "R7 masked source skipped");
    rd(8'h10, 32'h80, "R7 masked still pending");
    rd(8'h20, 32'h80, "R11 masked view");

    irq_src = '0;
    wr(8'h10, 32'h80);
    rd(8'h10, 32'h0, "R3 one clears");
    wr(8'h14, 32'h0);
    rd(8'h14, 32'h100, "R3 zero keeps");
    wr(8'h14, 32'h100);
    rd(8'h14, 32'h0, "R3 bank 1 clear");
    rd(8'h00, 32'h17C, "R6 source 95 vector");
    wr(8'h18, 32'h8000_0000);
    rd(8'h00, 32'h0, "R6 nothing live");
    repeat (2) @(negedge clk);
    chk("R8 line low", 32'(cpu_irq), 32'h0);

    // R4: clear and relatch on the same bit
    irq_src[33] = 1'b1;
    @(negedge clk);
    wr(8'h14, 32'h2);
    #2 chk("R4 clear wins on write edge", bus_rdata, 32'h0);
    rd(8'h14, 32'h2, "R4 relatched next edge");
    irq_src = '0;
    wr(8'h14, 32'h2);
    rd(8'h14, 32'h0, "R4 cleared with input low");

    // R9/R12: sense modes for source 0
    wr(8'h0C, 32'hFF);
    rd(8'h0C, 32'h3, "R12 two bits kept");
    rd(8'h10, 32'h0, "R9 rising: no edge yet");
    nmi_pin = 1'b0; @(negedge clk); nmi_pin = 1'b1;
    rd(8'h10, 32'h1, "R9 rising edge latched");
    rd(8'h00, 32'h0, "R9 source 0 never a vector");
    @(negedge clk);
    chk("R8 source 0 keeps line low", 32'(cpu_irq), 32'h0);
    wr(8'h0C, 32'h2);
    wr(8'h10, 32'h1);
    rd(8'h10, 32'h0, "R9 falling: cleared");
    nmi_pin = 1'b0;
    rd(8'h10, 32'h1, "R9 falling edge latched");
    nmi_pin = 1'b1;
    wr(8'h0C, 32'h1);
    wr(8'h10, 32'h1);
    rd(8'h10, 32'h1, "R9 high level relatches");
    wr(8'h0C, 32'h0);
    wr(8'h10, 32'h1);
    rd(8'h10, 32'h0, "R9 low level idle while pin high");

    // R10, R2, R5, R11: control and read-only registers
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h1, "R10 protection bit");
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0, "R2 unmapped address");
    wr(8'h00, 32'h0000_FFFF);
    rd(8'h00, 32'h0, "R5 vector ignores writes");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R11 view ignores writes");

    // R8: enable gating
    irq_src[50] = 1'b1;
    wr(8'h44, 32'h0);
    rd(8'h00, 32'h0, "R6 disabled source hidden");
    repeat (2) @(negedge clk);
    chk("R8 disabled source keeps line low", 32'(cpu_irq), 32'h0);
    wr(8'h44, 32'h0004_0000);
    rd(8'h00, 32'hC8, "R6 re-enabled source 50");
    @(negedge clk);
    chk("R8 re-enabled line high", 32'(cpu_irq), 32'h1);
    irq_src = '0;
    repeat (2) @(negedge clk);
    finish_up();
  end

  localparam logic [7:0] OFFS [16] = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h24,
                                       8'h28, 8'h40, 8'h44, 8'h48, 8'h50, 8'h54, 8'h58, 8'h04};
endmodule